// File: doc/BRIEF.md
# Interrupt-Driven Character Output Controller

This block sits on the CPU bus as a character output device. The CPU writes single bytes into a 128-slot ring buffer. The controller then passes those bytes one at a time to a display sink through a valid/ready handshake. When the buffer is full, a new byte is thrown away and counted. The block does not hold off the CPU.

After each printed byte, and after any dropped byte, the controller tells the CPU through a four-phase request/acknowledge exchange. It raises `irq_o` only when the shared acknowledge line is low. It holds the request until `iack_i` is high, then lowers it, and then waits for `iack_i` to fall. For the whole exchange, output stepping stops and the reported counters stay frozen, so the interrupt handler reads a stable picture. CPU writes into the buffer are still accepted during this time. When the acknowledge falls, the printed and outstanding counters return to zero. Drops that arrived during the exchange carry into the next report.

Top module: `char_out_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `status_o` is 0, `free_o` is 128 and `disp_valid_o` is 0.
- R2: Bytes reach `disp_data_o` in the order they were accepted, including when the read and write positions wrap past slot 127.
- R3: A write with fewer than 128 bytes stored is accepted and raises the stored count by one. `free_o` always equals 128 minus the stored count.
- R4: A write with 128 bytes stored is dropped and raises the drop counter by one. The buffer contents and order are left unchanged.
- R5: Each cycle with `disp_valid_o` and `disp_ready_i` both high removes exactly one byte from the front and raises the printed counter by one.
- R6: `irq_o` rises only when the printed or drop counter is nonzero and `iack_i` was low on the deciding edge. On that same edge the outstanding counter becomes 1. While `iack_i` stays high, no request is raised.
- R7: `irq_o` stays high until `iack_i` is seen high, and falls on the next clock edge.
- R8: From the edge that raises `irq_o` until the edge that sees `iack_i` low again, `disp_valid_o` is 0. CPU writes are still stored during this span.
- R9: During the exchange, the outstanding, printed and drop fields of `status_o` do not change. On the edge that sees `iack_i` fall, the printed and outstanding counters clear, and the drop counter takes the number of drops that arrived during the exchange.
- R10: The `status_o` layout is:
  - bits 4:0: outstanding requests
  - bits 9:5: printed-but-unreported bytes
  - bits 14:10: dropped bytes
  - bits 22:15: stored count
  - bits 31:23: zero
  
  Each 5-bit field saturates at 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU byte write strobe |
| wr_data_i | input | 8 | CPU byte to print |
| disp_data_o | output | 8 | Byte at the front of the buffer |
| disp_valid_o | output | 1 | Front byte offered to the display |
| disp_ready_i | input | 1 | Display takes the offered byte |
| irq_o | output | 1 | Interrupt request to the CPU |
| iack_i | input | 1 | Interrupt acknowledge from the CPU (shared line) |
| status_o | output | 32 | Packed counter snapshot |
| free_o | output | 8 | Free slots in the buffer |

## Verification
The main function is tried with four stimulus patterns, each chosen to tell a different kind of fault apart:

- **Full burst with the display stalled.** This separates acceptance from dropping at exactly 128 stored bytes. It also shows whether a drop made mid-exchange is reported now or deferred to the next report.
- **Single byte popped by hand.** A lone byte is released under manual acknowledge control. This pins the exact edges at which the printed count, the request and the clearing happen.
- **Long paced stream under an automatic responder.** More than 128 bytes drain while writes keep arriving. This exposes ordering faults at the wrap of the ring, and any stepping that continues during an exchange.
- **Overfill while the acknowledge line is held busy.** This shows that no request starts on a busy line, and that the drop field saturates at 31.

// File: rtl/cout_pkg.sv
package cout_pkg;
  localparam int unsigned FLD_W = 5;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_RAISED = 2'd1,
    HS_ACKED  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/cout_ring.sv
// Circular byte store: front index plus level; DEPTH must be a power of two.
module cout_ring #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] front_q;
  logic [CNT_W-1:0] level_q;
  logic [PTR_W-1:0] tail;
  logic             do_push, do_pop;

  assign full_o  = (level_q == CNT_W'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign tail    = front_q + level_q[PTR_W-1:0];
  assign head_o  = mem_q[front_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[tail] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q <= '0;
      level_q <= '0;
    end else begin
      if (do_pop) front_q <= front_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/cout_hs.sv
// Four-phase request engine with frozen report counters.
module cout_hs
  import cout_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          printed_i,
  input  logic          dropped_i,
  input  logic          iack_i,
  output logic          irq_o,
  output logic          hold_o,
  output logic [CW-1:0] pend_o,
  output logic [CW-1:0] disc_o,
  output logic [CW-1:0] outst_o
);
  localparam logic [CW-1:0] CMAX = '1;

  hs_state_e     state_q;
  logic [CW-1:0] pend_q, disc_q, late_q, outst_q;

  function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v, input logic en);
    return (en && v != CMAX) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      pend_q  <= '0;
      disc_q  <= '0;
      late_q  <= '0;
      outst_q <= '0;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          pend_q <= inc_sat(pend_q, printed_i);
          disc_q <= inc_sat(disc_q, dropped_i);
          if ((pend_q != '0 || disc_q != '0) && !iack_i) begin
            state_q <= HS_RAISED;
            outst_q <= inc_sat(outst_q, 1'b1);
          end
        end
        HS_RAISED: begin
          late_q <= inc_sat(late_q, dropped_i);
          if (iack_i) state_q <= HS_ACKED;
        end
        HS_ACKED: begin
          if (!iack_i) begin
            state_q <= HS_IDLE;
            pend_q  <= '0;
            outst_q <= '0;
            disc_q  <= inc_sat(late_q, dropped_i);
            late_q  <= '0;
          end else begin
            late_q <= inc_sat(late_q, dropped_i);
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign irq_o   = (state_q == HS_RAISED);
  assign hold_o  = (state_q != HS_IDLE);
  assign pend_o  = pend_q;
  assign disc_o  = disc_q;
  assign outst_o = outst_q;
endmodule

// File: rtl/char_out_ctrl.sv
module char_out_ctrl
  import cout_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DW     = 8,
  parameter int unsigned STAT_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     disp_data_o,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic              irq_o,
  input  logic              iack_i,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  free_o
);
  localparam int unsigned OFS_PEND = FLD_W;
  localparam int unsigned OFS_DISC = 2 * FLD_W;
  localparam int unsigned OFS_CNT  = 3 * FLD_W;
  localparam int unsigned USED_W   = OFS_CNT + CNT_W;
  localparam int unsigned CW       = 8;

  logic [CNT_W-1:0] level;
  logic             full, empty, hold, pop, drop;
  logic [CW-1:0]    pend, disc, outst;

  function automatic logic [FLD_W-1:0] sat_fld(input logic [CW-1:0] v);
    return (v > CW'((1 << FLD_W) - 1)) ? '1 : v[FLD_W-1:0];
  endfunction

  assign disp_valid_o = !empty && !hold;
  assign pop          = disp_valid_o && disp_ready_i;
  assign drop         = wr_en_i && full;

  cout_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (disp_data_o),
    .level_o     (level),
    .full_o      (full),
    .empty_o     (empty)
  );

  cout_hs #(.CW(CW)) u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .printed_i (pop),
    .dropped_i (drop),
    .iack_i    (iack_i),
    .irq_o     (irq_o),
    .hold_o    (hold),
    .pend_o    (pend),
    .disc_o    (disc),
    .outst_o   (outst)
  );

  always_comb begin
    status_o = '0;
    status_o[FLD_W-1:0]              = sat_fld(outst);
    status_o[OFS_PEND +: FLD_W]      = sat_fld(pend);
    status_o[OFS_DISC +: FLD_W]      = sat_fld(disc);
    status_o[OFS_CNT  +: CNT_W]      = level;
  end

  generate
    if (USED_W > STAT_W) begin : g_bad_width
      initial $error("status word too narrow");
    end
  endgenerate

  assign free_o = CNT_W'(DEPTH) - level;
endmodule

// File: rtl/cout_checker.sv
module cout_checker #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned STAT_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              disp_valid_o,
  input logic              disp_ready_i,
  input logic              irq_o,
  input logic              iack_i,
  input logic [STAT_W-1:0] status_o,
  input logic [CNT_W-1:0]  free_o
);
  // R6: request starts only on a quiet acknowledge line
  a_r6_rise_on_quiet_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(iack_i));

  // R6: a new request always reports one outstanding
  a_r6_outstanding_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[4:0] == 5'd1));

  // R7: request only drops after acknowledge was seen
  a_r7_fall_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(iack_i));

  // R7: request held while acknowledge is low
  a_r7_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !iack_i) |=> irq_o);

  // R8: no display stepping while a request is up
  a_r8_no_step_in_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !disp_valid_o);

  // R9: report fields frozen across a held request
  a_r9_frozen_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_o)) |-> $stable(status_o[14:0]));

  // R3: free space and stored count agree
  a_r3_free_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(free_o) + 32'(status_o[22:15])) == DEPTH);

  // R10: upper status bits unused
  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_W-1:23] == '0);
endmodule

bind char_out_ctrl cout_checker #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .disp_valid_o (disp_valid_o),
  .disp_ready_i (disp_ready_i),
  .irq_o        (irq_o),
  .iack_i       (iack_i),
  .status_o     (status_o),
  .free_o       (free_o)
);

// File: tb/sim_char_out_ctrl.sv
`timescale 1ns/1ps
module sim_char_out_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  disp_data;
  logic        disp_valid;
  logic        disp_ready = 0;
  logic        irq;
  logic        iack = 0;
  logic [31:0] status;
  logic [7:0]  free;

  int checks = 0, errors = 0;
  int seq = 0;
  int printed = 0;
  bit auto_ack = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  char_out_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .disp_data_o(disp_data), .disp_valid_o(disp_valid), .disp_ready_i(disp_ready),
    .irq_o(irq), .iack_i(iack), .status_o(status), .free_o(free)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 8'hFF);
  endfunction

  // driver: writes n bytes back to back, queueing those expected to be accepted
  task automatic write_burst(input int n, input int accept);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_en = 1; wr_data = pat(seq);
      if (i < accept) exp_q.push_back(pat(seq));
      seq++;
    end
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic set_iack(input logic v);
    @(posedge clk); #1;
    iack = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wait_drained;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (status == 0 && !irq && exp_q.size() == 0 && !iack) break;
    end
  endtask

  // monitor: scoreboard pop on each transfer
  always @(negedge clk) begin
    if (rst_n && disp_valid && disp_ready) begin
      printed++;
      if (exp_q.size() == 0) chk("R2", "unexpected byte", int'(disp_data), -1);
      else chk("R2", "byte order", int'(disp_data), int'(exp_q.pop_front()));
    end
  end

  // automatic acknowledge responder
  always @(posedge clk) begin
    #1;
    if (auto_ack) begin
      if (irq && !iack) iack = 1;
      else if (iack && !irq) iack = 0;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "status", int'(status), 0);
    chk("R1", "free", int'(free), 128);
    chk("R1", "valid", int'(disp_valid), 0);
    @(posedge clk); #1 rst_n = 1;

    // fill 129 with display stalled: one drop
    write_burst(129, 128);
    repeat (3) @(negedge clk);
    chk("R3", "count", int'(status[22:15]), 128);
    chk("R3", "free", int'(free), 0);
    chk("R4", "discard", int'(status[14:10]), 1);
    chk("R6", "irq up", int'(irq), 1);
    chk("R6", "outstanding", int'(status[4:0]), 1);
    chk("R8", "valid paused", int'(disp_valid), 0);
    write_burst(1, 0);  // dropped during exchange
    @(negedge clk);
    chk("R9", "discard frozen", int'(status[14:10]), 1);
    set_iack(1);
    chk("R7", "irq fell", int'(irq), 0);
    chk("R9", "outstanding frozen", int'(status[4:0]), 1);
    set_iack(0);
    chk("R9", "outstanding cleared", int'(status[4:0]), 0);
    chk("R9", "late drop carried", int'(status[14:10]), 1);
    chk("R9", "irq low", int'(irq), 0);
    @(negedge clk);
    chk("R6", "re-raise on late drop", int'(irq), 1);

    // drain the 128 in order
    auto_ack = 1;
    @(posedge clk); #1 disp_ready = 1;
    wait_drained();
    chk("R2", "all printed", printed, 128);
    chk("R3", "free after drain", int'(free), 128);
    chk("R9", "status after drain", int'(status), 0);

    // single byte with manual acknowledge
    auto_ack = 0;
    @(posedge clk); #1 disp_ready = 0;
    write_burst(1, 1);
    @(negedge clk); @(negedge clk);
    chk("R5", "valid offered", int'(disp_valid), 1);
    @(posedge clk); #1 disp_ready = 1;
    @(posedge clk); #1 disp_ready = 0;
    @(negedge clk);
    chk("R5", "printed count", int'(status[9:5]), 1);
    chk("R5", "count emptied", int'(status[22:15]), 0);
    chk("R6", "irq not yet", int'(irq), 0);
    @(negedge clk);
    chk("R6", "irq raised", int'(irq), 1);
    chk("R6", "outstanding", int'(status[4:0]), 1);
    write_burst(1, 1);  // accepted during exchange
    @(negedge clk);
    chk("R8", "write stored in exchange", int'(status[22:15]), 1);
    chk("R8", "valid held off", int'(disp_valid), 0);
    set_iack(1);
    chk("R9", "printed frozen", int'(status[9:5]), 1);
    set_iack(0);
    chk("R9", "status after clear", int'(status), 32'd1 << 15);
    chk("R8", "stepping resumed", int'(disp_valid), 1);

    // long paced stream across the ring wrap
    auto_ack = 1;
    @(posedge clk); #1 disp_ready = 1;
    for (int i = 0; i < 200; i++) begin
      write_burst(1, 1);
      @(posedge clk);
    end
    wait_drained();
    chk("R2", "wrap stream printed", printed, 330);

    // overfill with acknowledge line busy: no raise, drop field saturates
    auto_ack = 0;
    @(posedge clk); #1 disp_ready = 0; iack = 1;
    write_burst(168, 128);
    repeat (3) @(negedge clk);
    chk("R6", "no raise on busy line", int'(irq), 0);
    chk("R10", "discard saturated", int'(status[14:10]), 31);
    chk("R10", "count field", int'(status[22:15]), 128);
    chk("R10", "upper bits", int'(status[31:23]), 0);
    set_iack(0);
    @(negedge clk);
    chk("R6", "raise after line quiet", int'(irq), 1);
    auto_ack = 1;
    @(posedge clk); #1 disp_ready = 1;
    wait_drained();
    chk("R2", "final printed", printed, 458);
    chk("R1", "status idle", int'(status), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule